// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers a vector of interrupt request lines into a latched source-pending register and picks one of them for the processor. Every source has a mask bit that blocks it and a mode bit that sends it to the fast-request output instead of the normal one. A normal-mode source that wins arbitration is recorded in a one-hot in-service register, and that register drives the normal request output. The choice stays fixed until software acknowledges it.

Software sees four word-wide registers through a small register bus. A write strobe, a two-bit address and write data update a register on a clock edge. Read data follows the address combinationally. Both pending registers clear on a written 1. The mask and mode registers load the written word as it stands.

The in-service logic is a two-state machine. In IDLE the in-service register is zero. The GRANT transition to HOLD loads the one-hot winner as soon as any pending, unmasked normal-mode source exists. In HOLD the winner is kept. The RELEASE transition back to IDLE happens when software writes a 1 to the held bit of the in-service register.

Top module: `prio_int_ctrl`

## Requirements
- R1: After reset the source-pending (address 0) and in-service (address 1) registers read 0, the mask register (address 2) reads all ones, the mode register (address 3) reads 0, and both `irq_o` and `fiq_o` are low.
- R2: A source whose request line is high at a clock edge has its source-pending bit set after that edge. The bit stays set after the line drops, and any number of bits may be set together.
- R3: A bus write to address 0 clears every source-pending bit written as 1 and leaves bits written as 0 unchanged. A source whose request is high at the same edge stays set.
- R4: The in-service register holds at most one 1. When it is zero, it loads the lowest-indexed source that is pending, unmasked and in normal mode, one clock edge after that pending bit becomes visible.
- R5: While the in-service register is nonzero it does not change, whatever happens to pending, mask or mode. The exception is a write to address 1 with a 1 in the held bit, which clears it. Writing zeros there has no effect.
- R6: `irq_o` is high exactly when the in-service register is nonzero.
- R7: A source whose mask bit (address 2) is 1 still latches into the source-pending register, but it is never chosen for service and never drives `fiq_o`. Clearing the mask bit lets it be chosen at the next edge.
- R8: A source whose mode bit (address 3) is 1 drives `fiq_o` high, with no extra register stage, while its pending bit is set and its mask bit is 0. It never enters the in-service register, even when it has the lowest index.
- R9: When several mode bits are 1, only the lowest-indexed one selects fast handling. The other sources with mode bit 1 are arbitrated as normal sources. The mode register reads back exactly as written.
- R10: A write to address 2 or 3 replaces the whole mask or mode word, and `bus_rdata` shows the register chosen by `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Interrupt request lines, sampled at each edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 pending, 1 in-service, 2 mask, 3 mode |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data of the selected register |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach from the ports is a held in-service choice that becomes stale. This happens when a lower-indexed source arrives, or the held source is masked, while HOLD is active. The bench reaches it by raising one request and waiting for GRANT, then raising a lower-indexed request, writing zeros to the in-service register, and only then writing the held bit. It checks that the choice stayed put and that the next GRANT selects the newcomer. Exhaustive sweeps over every single source, every pair of sources and every fast-source position compare against a lowest-index winner that the bench computes itself.

// File: rtl/prio_int_pkg.sv
package prio_int_pkg;
    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_SVC  = 2'd1,
        REG_MASK = 2'd2,
        REG_MODE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_HOLD = 1'b1
    } svc_state_e;
endpackage

// File: rtl/prio_int_lsb.sv
module prio_int_lsb #(
    parameter int N = 32
) (
    input  logic [N-1:0] vec_i,
    output logic [N-1:0] onehot_o,
    output logic         any_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign onehot_o[i] = vec_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | vec_i[i];
    end

    assign any_o = seen[N];
endmodule

// File: rtl/prio_int_regs.sv
module prio_int_regs
    import prio_int_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_req,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] src_pend,
    output logic [N-1:0] int_mask,
    output logic [N-1:0] int_mode
);
    logic [N-1:0] pend_clr;

    always_comb begin
        pend_clr = '0;
        if (wr_en && wr_sel == REG_PEND) begin
            pend_clr = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_pend <= '0;
            int_mask <= '1;
            int_mode <= '0;
        end else begin
            src_pend <= (src_pend & ~pend_clr) | src_req;
            if (wr_en && wr_sel == REG_MASK) begin
                int_mask <= wr_data;
            end
            if (wr_en && wr_sel == REG_MODE) begin
                int_mode <= wr_data;
            end
        end
    end
endmodule

// File: rtl/prio_int_svc.sv
module prio_int_svc
    import prio_int_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_onehot,
    input  logic         cand_any,
    input  logic         clr_en,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] in_svc,
    output logic         busy
);
    svc_state_e   state_q, state_d;
    logic [N-1:0] svc_q, svc_d;

    always_comb begin
        state_d = state_q;
        svc_d   = svc_q;
        unique case (state_q)
            SVC_IDLE: begin
                if (cand_any) begin
                    state_d = SVC_HOLD;
                    svc_d   = cand_onehot;
                end
            end
            SVC_HOLD: begin
                if (clr_en && |(clr_data & svc_q)) begin
                    state_d = SVC_IDLE;
                    svc_d   = '0;
                end
            end
            default: begin
                state_d = SVC_IDLE;
                svc_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            svc_q   <= '0;
        end else begin
            state_q <= state_d;
            svc_q   <= svc_d;
        end
    end

    always_comb begin
        busy   = (state_q == SVC_HOLD);
        in_svc = svc_q;
    end
endmodule

// File: rtl/prio_int_ctrl.sv
module prio_int_ctrl
    import prio_int_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    reg_sel_e         sel;
    logic [N_SRC-1:0] src_pend;
    logic [N_SRC-1:0] int_mask;
    logic [N_SRC-1:0] int_mode;
    logic [N_SRC-1:0] fast_sel;
    logic             fast_any;
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] normal_cand;
    logic [N_SRC-1:0] cand_onehot;
    logic             cand_any;
    logic [N_SRC-1:0] in_svc;
    logic             svc_busy;
    logic             svc_clr;

    assign sel = reg_sel_e'(bus_addr);

    prio_int_regs #(.N(N_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .wr_en    (bus_wr),
        .wr_sel   (sel),
        .wr_data  (bus_wdata),
        .src_pend (src_pend),
        .int_mask (int_mask),
        .int_mode (int_mode)
    );

    prio_int_lsb #(.N(N_SRC)) u_fast_pick (
        .vec_i    (int_mode),
        .onehot_o (fast_sel),
        .any_o    (fast_any)
    );

    assign live        = src_pend & ~int_mask;
    assign normal_cand = live & ~fast_sel;

    prio_int_lsb #(.N(N_SRC)) u_norm_pick (
        .vec_i    (normal_cand),
        .onehot_o (cand_onehot),
        .any_o    (cand_any)
    );

    assign svc_clr = bus_wr && (sel == REG_SVC);

    prio_int_svc #(.N(N_SRC)) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_onehot (cand_onehot),
        .cand_any    (cand_any),
        .clr_en      (svc_clr),
        .clr_data    (bus_wdata),
        .in_svc      (in_svc),
        .busy        (svc_busy)
    );

    always_comb begin
        irq_o = svc_busy;
        fiq_o = fast_any && |(live & fast_sel);
    end

    always_comb begin
        unique case (sel)
            REG_PEND: bus_rdata = src_pend;
            REG_SVC:  bus_rdata = in_svc;
            REG_MASK: bus_rdata = int_mask;
            REG_MODE: bus_rdata = int_mode;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/prio_int_chk.sv
module prio_int_chk #(
    parameter int N_SRC = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [N_SRC-1:0] bus_wdata,
    input logic [N_SRC-1:0] src_pend,
    input logic [N_SRC-1:0] int_mask,
    input logic [N_SRC-1:0] int_mode,
    input logic [N_SRC-1:0] in_svc,
    input logic             irq_o,
    input logic             fiq_o
);
    p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> ((src_pend & $past(src_req)) == $past(src_req)));

    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> (($past(src_pend) & ~src_pend) == '0));

    p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
            ((src_pend & $past(bus_wdata) & ~$past(src_req)) == '0));

    p_svc_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_svc));

    p_svc_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc == '0) |=> ((in_svc & ~($past(src_pend) & ~$past(int_mask))) == '0));

    p_svc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc != '0 && !(bus_wr && bus_addr == 2'd1)) |=> (in_svc == $past(in_svc)));

    p_irq_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (in_svc != '0));

    p_fiq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ((src_pend & ~int_mask & int_mode) != '0));
endmodule

bind prio_int_ctrl prio_int_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_pend  (src_pend),
    .int_mask  (int_mask),
    .int_mode  (int_mode),
    .in_svc    (in_svc),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/prio_int_ctrl_tb.sv
`timescale 1ns/1ps
module prio_int_ctrl_tb;
    localparam int N = 32;
    localparam logic [1:0] A_PEND = 2'd0;
    localparam logic [1:0] A_SVC  = 2'd1;
    localparam logic [1:0] A_MASK = 2'd2;
    localparam logic [1:0] A_MODE = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq_o;
    logic         fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_int_ctrl #(.N_SRC(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic clean();
        src_req = '0;
        wr(A_PEND, '1);
        wr(A_SVC, '1);
        tick();
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        logic [N-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(A_PEND, v); chk("R1 pend", v, '0);
        rd(A_SVC, v);  chk("R1 svc", v, '0);
        rd(A_MASK, v); chk("R1 mask", v, '1);
        rd(A_MODE, v); chk("R1 mode", v, '0);
        chk("R1 irq", {31'd0, irq_o}, '0);
        chk("R1 fiq", {31'd0, fiq_o}, '0);

        // R10 readback
        wr(A_MASK, 32'h5A5A_0F0F);
        rd(A_MASK, v); chk("R10 mask readback", v, 32'h5A5A_0F0F);
        wr(A_MODE, 32'h0000_0000);
        rd(A_MODE, v); chk("R10 mode readback", v, '0);

        // R7 masked source latches but is not served
        wr(A_MASK, '1);
        src_req = bit_of(4);
        tick();
        src_req = '0;
        tick();
        rd(A_PEND, v); chk("R7 masked pend", v, bit_of(4));
        rd(A_SVC, v);  chk("R7 masked svc", v, '0);
        chk("R7 masked irq", {31'd0, irq_o}, '0);
        wr(A_MASK, '0);
        tick();
        rd(A_SVC, v);  chk("R7 unmask loads", v, bit_of(4));
        clean();

        // R2/R4/R6 single-source sweep
        for (int i = 0; i < N; i++) begin
            src_req = bit_of(i);
            tick();
            src_req = '0;
            rd(A_PEND, v); chk("R2 pend set", v, bit_of(i));
            chk("R4 not yet loaded", {31'd0, irq_o}, '0);
            tick();
            rd(A_SVC, v); chk("R4 single svc", v, bit_of(i));
            chk("R6 irq high", {31'd0, irq_o}, 32'd1);
            clean();
            chk("R6 irq low after clear", {31'd0, irq_o}, '0);
        end

        // R4 pair sweep: lowest index wins
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                src_req = bit_of(i) | bit_of(j);
                tick();
                src_req = '0;
                tick();
                rd(A_SVC, v); chk("R4 pair priority", v, bit_of(i));
                clean();
            end
        end

        // R7 mask excludes lower source
        wr(A_MASK, bit_of(3));
        src_req = bit_of(3) | bit_of(9);
        tick();
        src_req = '0;
        tick();
        rd(A_PEND, v); chk("R7 pend holds masked", v, bit_of(3) | bit_of(9));
        rd(A_SVC, v);  chk("R7 masked skipped", v, bit_of(9));
        clean();
        wr(A_MASK, '0);

        // R3 write-one-to-clear
        src_req = bit_of(3) | bit_of(6);
        tick();
        src_req = bit_of(3);
        wr(A_PEND, bit_of(3) | bit_of(6));
        rd(A_PEND, v); chk("R3 set wins over clear", v, bit_of(3));
        src_req = '0;
        wr(A_PEND, '0);
        rd(A_PEND, v); chk("R3 zeros leave bits", v, bit_of(3));
        wr(A_PEND, bit_of(3));
        rd(A_PEND, v); chk("R3 one clears", v, '0);
        clean();

        // R5 stale hold
        src_req = bit_of(5);
        tick();
        src_req = '0;
        tick();
        rd(A_SVC, v); chk("R5 first grant", v, bit_of(5));
        src_req = bit_of(2);
        tick();
        src_req = '0;
        wr(A_MASK, bit_of(5));
        tick();
        rd(A_SVC, v); chk("R5 hold despite newcomer", v, bit_of(5));
        wr(A_SVC, '0);
        rd(A_SVC, v); chk("R5 zero write ignored", v, bit_of(5));
        wr(A_SVC, bit_of(5));
        rd(A_SVC, v); chk("R5 release", v, '0);
        tick();
        rd(A_SVC, v); chk("R5 next grant", v, bit_of(2));
        clean();
        wr(A_MASK, '0);

        // R8 fast sweep with all requests
        for (int f = 0; f < N; f++) begin
            wr(A_MODE, bit_of(f));
            src_req = '1;
            tick();
            src_req = '0;
            chk("R8 fiq high", {31'd0, fiq_o}, 32'd1);
            tick();
            rd(A_SVC, v); chk("R8 fast not served", v, (f == 0) ? bit_of(1) : bit_of(0));
            clean();
            chk("R8 fiq drops", {31'd0, fiq_o}, '0);
        end

        // R8 masked fast source
        wr(A_MODE, bit_of(7));
        wr(A_MASK, bit_of(7));
        src_req = bit_of(7);
        tick();
        src_req = '0;
        chk("R8 masked fiq low", {31'd0, fiq_o}, '0);
        wr(A_MASK, '0);
        chk("R8 unmasked fiq high", {31'd0, fiq_o}, 32'd1);
        tick();
        rd(A_SVC, v); chk("R8 fast svc empty", v, '0);
        clean();

        // R9 several mode bits
        wr(A_MODE, 32'h0000_00A0);
        rd(A_MODE, v); chk("R9 mode readback", v, 32'h0000_00A0);
        src_req = bit_of(7);
        tick();
        src_req = '0;
        chk("R9 upper mode bit not fast", {31'd0, fiq_o}, '0);
        tick();
        rd(A_SVC, v); chk("R9 upper mode bit served", v, bit_of(7));
        clean();
        src_req = bit_of(5) | bit_of(7);
        tick();
        src_req = '0;
        chk("R9 lowest mode bit fast", {31'd0, fiq_o}, 32'd1);
        tick();
        rd(A_SVC, v); chk("R9 normal among modes", v, bit_of(7));
        clean();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule